// File: doc/BRIEF.md
# Keyboard Controller Handshake Flags

This block sits between a main processor and a small keyboard-scanning microcontroller. The microcontroller signals the main side by toggling bits of its 8-bit output port. The block keeps a copy of the last value written to that port. It compares each new write against that copy, so that a high-to-low transition on one port bit raises an interrupt request and a high-to-low transition on another bit raises a sync flag. The main processor acknowledges a transfer by reading the microcontroller's data port. That read strobe clears both the interrupt request and the sync flag.

The sync flag is a single output. The main side reads it as a status input, and the same wire drives the microcontroller's test input. A third port bit is passed through as a continuation level. Each of the two flags is a small two-state machine with the states FLAG_IDLE and FLAG_RAISED:
- The transition SET_EVENT moves a flag from FLAG_IDLE to FLAG_RAISED.
- The transition ACK_READ moves it back to FLAG_IDLE, unless a SET_EVENT occurs in the same cycle.
- In every other case the flag stays where it is (HOLD).

Top module: `kbd_link_flags`

## Requirements
- R1: A port write where the stored copy has bit 6 = 1 and the new value has bit 6 = 0 makes `irq_o` 1 from the next clock edge on.
- R2: A port write where the stored copy has bit 7 = 1 and the new value has bit 7 = 0 makes `sync_o` 1 from the next clock edge on.
- R3: A cycle with `host_rd` = 1 and no set event clears both `irq_o` and `sync_o` at the next edge.
- R4: `cont_o` equals bit 5 of the most recently written port value, and it changes only after a port write.
- R5: Writes that raise a bit 6 or bit 7 from 0 to 1, or leave it unchanged, do not set the corresponding flag.
- R6: After reset, `irq_o`, `sync_o` and `cont_o` are 0, and the stored port copy is 0x00. A first write of 0x00 therefore creates no edge.
- R7: If a set event for a flag and `host_rd` fall in the same cycle, that flag ends up set.
- R8: With no write and no read, both flags keep their value. A further falling edge while a flag is already set leaves it set.
- R9: An edge is judged against the last written value only. It is not judged against time, so writes of an unchanged value create no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr | input | 1 | Microcontroller port write strobe |
| port_data | input | 8 | Value being written to the port |
| host_rd | input | 1 | Main-side read strobe of the data port (acknowledge) |
| irq_o | output | 1 | Interrupt request to the main processor |
| sync_o | output | 1 | Sync flag, also the microcontroller test input |
| cont_o | output | 1 | Continuation level (bit 5 of last written value) |

## Verification
The port write that produces a falling edge and the acknowledging host read can land in the same cycle, so a flag sees SET_EVENT and ACK_READ together. The bench drives a write of 0x00 over a stored 0xC0 while `host_rd` is high in that same cycle. After the edge it requires both flags to be 1. A following read on its own must then clear them, which shows that the set won over the clear and did not merely delay it.

// File: rtl/kbd_link_pkg.sv
package kbd_link_pkg;
    localparam int PORT_W   = 8;
    localparam int IRQ_BIT  = 6;
    localparam int SYNC_BIT = 7;
    localparam int CONT_BIT = 5;

    typedef enum logic [0:0] {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_t;
endpackage

// File: rtl/port_edge_track.sv
module port_edge_track #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] data,
    output logic [W-1:0] fall,
    output logic [W-1:0] stored
);
    // Shadow of the last written value
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored <= '0;
        else if (wr)
            stored <= data;
    end

    // Bits that go from 1 in the shadow to 0 in the new write
    always_comb begin
        fall = '0;
        if (wr)
            fall = stored & ~data;
    end
endmodule

// File: rtl/hs_flag_fsm.sv
module hs_flag_fsm
    import kbd_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic active
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (set_ev) state_d = FLAG_RAISED;
            FLAG_RAISED: if (clr_ev && !set_ev) state_d = FLAG_IDLE;
            default:     state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FLAG_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        active = (state_q == FLAG_RAISED);
    end
endmodule

// File: rtl/kbd_link_flags.sv
module kbd_link_flags
    import kbd_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic [PORT_W-1:0] port_data,
    input  logic              host_rd,
    output logic              irq_o,
    output logic              sync_o,
    output logic              cont_o
);
    logic [PORT_W-1:0] fall;
    logic [PORT_W-1:0] port_q;

    port_edge_track #(.W(PORT_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (port_wr),
        .data   (port_data),
        .fall   (fall),
        .stored (port_q)
    );

    hs_flag_fsm u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (fall[IRQ_BIT]),
        .clr_ev (host_rd),
        .active (irq_o)
    );

    hs_flag_fsm u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (fall[SYNC_BIT]),
        .clr_ev (host_rd),
        .active (sync_o)
    );

    assign cont_o = port_q[CONT_BIT];
endmodule

// File: rtl/kbd_link_flags_chk.sv
module kbd_link_flags_chk
    import kbd_link_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              port_wr,
    input logic [PORT_W-1:0] port_data,
    input logic              host_rd,
    input logic [PORT_W-1:0] port_q,
    input logic              irq_o,
    input logic              sync_o,
    input logic              cont_o
);
    // R1
    irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_q[IRQ_BIT] && !port_data[IRQ_BIT]) |=> irq_o);

    // R2
    sync_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_q[SYNC_BIT] && !port_data[SYNC_BIT]) |=> sync_o);

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !port_wr) |=> (!irq_o && !sync_o));

    // R4
    cont_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (cont_o == $past(port_data[CONT_BIT])));

    // R4
    cont_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(cont_o));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_wr && !host_rd) |=> ($stable(irq_o) && $stable(sync_o)));

    // R5
    no_spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !(port_wr && port_q[IRQ_BIT] && !port_data[IRQ_BIT])) |=> !irq_o);
endmodule

bind kbd_link_flags kbd_link_flags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_wr   (port_wr),
    .port_data (port_data),
    .host_rd   (host_rd),
    .port_q    (port_q),
    .irq_o     (irq_o),
    .sync_o    (sync_o),
    .cont_o    (cont_o)
);

// File: tb/tb_kbd_link_flags.sv
module tb_kbd_link_flags;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_wr = 1'b0;
    logic [7:0] port_data = 8'h00;
    logic       host_rd = 1'b0;
    logic       irq_o, sync_o, cont_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_link_flags dut (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_data(port_data),
        .host_rd(host_rd), .irq_o(irq_o), .sync_o(sync_o), .cont_o(cont_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: {irq,sync,cont} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one cycle of stimulus, sampled 1 time unit after the edge
    task automatic cycle(input logic wr, input logic [7:0] d, input logic rd);
        @(negedge clk);
        port_wr = wr; port_data = d; host_rd = rd;
        @(posedge clk); #1;
        port_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R6 reset", {irq_o, sync_o, cont_o}, 3'b000);
        @(negedge clk); rst_n = 1'b1;
        cycle(1'b1, 8'h00, 1'b0);
        check("R6 first write of 0x00", {irq_o, sync_o, cont_o}, 3'b000);
    endtask

    task automatic t_rising_no_set;
        cycle(1'b1, 8'hE0, 1'b0);
        check("R5 rising edges only, R4 cont=1", {irq_o, sync_o, cont_o}, 3'b001);
        cycle(1'b1, 8'hE0, 1'b0);
        check("R9 same value again", {irq_o, sync_o, cont_o}, 3'b001);
    endtask

    task automatic t_both_fall;
        cycle(1'b1, 8'h20, 1'b0);
        check("R1 R2 both fall", {irq_o, sync_o, cont_o}, 3'b111);
        cycle(1'b1, 8'h00, 1'b0);
        check("R4 cont drops, flags held", {irq_o, sync_o, cont_o}, 3'b110);
        cycle(1'b0, 8'hFF, 1'b0);
        check("R8 idle hold, R4 no write", {irq_o, sync_o, cont_o}, 3'b110);
        cycle(1'b0, 8'h00, 1'b1);
        check("R3 read clears both", {irq_o, sync_o, cont_o}, 3'b000);
    endtask

    task automatic t_irq_only;
        cycle(1'b1, 8'h40, 1'b0);
        check("R5 bit6 rise", {irq_o, sync_o, cont_o}, 3'b000);
        cycle(1'b1, 8'h00, 1'b0);
        check("R1 bit6 fall only", {irq_o, sync_o, cont_o}, 3'b100);
        cycle(1'b1, 8'h40, 1'b0);
        cycle(1'b1, 8'h00, 1'b0);
        check("R8 second fall while set", {irq_o, sync_o, cont_o}, 3'b100);
        cycle(1'b0, 8'h00, 1'b1);
        check("R3 read clears irq", {irq_o, sync_o, cont_o}, 3'b000);
    endtask

    task automatic t_sync_only;
        cycle(1'b1, 8'hA0, 1'b0);
        cycle(1'b1, 8'h20, 1'b0);
        check("R2 bit7 fall only", {irq_o, sync_o, cont_o}, 3'b011);
        cycle(1'b0, 8'h00, 1'b1);
        check("R3 read clears sync", {irq_o, sync_o, cont_o}, 3'b001);
    endtask

    task automatic t_collision;
        cycle(1'b1, 8'hC0, 1'b0);
        cycle(1'b1, 8'h00, 1'b1);
        check("R7 set wins over read", {irq_o, sync_o, cont_o}, 3'b110);
        cycle(1'b0, 8'h00, 1'b1);
        check("R3 later read clears", {irq_o, sync_o, cont_o}, 3'b000);
        cycle(1'b0, 8'h00, 1'b1);
        check("R3 read with nothing pending", {irq_o, sync_o, cont_o}, 3'b000);
    endtask

    initial begin
        t_reset();
        t_rising_no_set();
        t_both_fall();
        t_irq_only();
        t_sync_only();
        t_collision();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule